// File: doc/BRIEF.md
# Ring Partial Sum Reduction Array

This block combines partial sums that are spread over a set of processing nodes. There are `NODES` nodes, and each one keeps `NODES` partial sums, one for each result index. A shared load port fills these sums while the array is idle. A start pulse then begins the reduction. The nodes form a closed one-way ring: each node passes one value to its right neighbour and takes one value from its left neighbour. The value taken in is added to the local entry for the same index.

The choice of which index each node passes on each step is fixed. It is arranged so that every node makes a useful addition on every step. After `NODES-1` steps, each node holds the complete sum for a different index. Each step takes one clock cycle, and all nodes step together. Node `j` finishes with the total for index `(j+1) mod NODES`. A single `done` pulse marks the end of the reduction. The totals stay on a registered result port until the next reduction finishes.

Top module: `ring_psum_reduce`

## Requirements
- R1: While the array is idle, a cycle with `load_en` high writes `load_data` into entry `load_idx` of node `load_node`.
- R2: On ring step `t` (counted from 0), node `j` sends its entry for index `(j - t) mod NODES` to node `(j+1) mod NODES`. The last node wraps around to node 0.
- R3: A received value is added into the receiver's entry for the same index. The addition wraps in two's complement at `WIDTH` bits, and the updated entry is the one sent on the next step.
- R4: When the reduction completes, slice `j` of `result` (bits `j*WIDTH +: WIDTH`) holds the sum, modulo 2^WIDTH, of every node's loaded entry for index `(j+1) mod NODES`.
- R5: `done` is high for exactly one cycle. It rises after the `(NODES-1)`th rising edge following the edge that samples `start`.
- R6: A `start` pulse that arrives while a reduction is running has no effect. The run keeps its timing, and no extra `done` pulse follows.
- R7: A `load_en` cycle during a running reduction writes nothing and does not change the results.
- R8: `result` changes only on the cycle `done` is raised. Loads made after completion leave it unchanged.
- R9: After reset, `done` is low and `result` and all entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a reduction when the array is idle |
| load_en | input | 1 | Write enable for one partial sum |
| load_node | input | $clog2(NODES) | Node selected for the write |
| load_idx | input | $clog2(NODES) | Result index of the entry being written |
| load_data | input | WIDTH | Partial sum value |
| done | output | 1 | One-cycle completion pulse |
| result | output | NODES*WIDTH | Completed sums, one slice per node |

## Verification
The assertions run on every cycle and check four things:
- the step counter advances by one and stays in range, and a mid-run start does not disturb it;
- `done` lasts only one cycle and only follows the final step;
- node storage changes only through a load or a ring step, and a step adds exactly the neighbour's value into the receiving entry;
- `result` moves only while `done` is high.

Only the bench scenarios can show that the rotation schedule gives the correct totals for every node. The scenarios use per-node patterns in which any mis-routed index changes a total, include wrapping values, and apply loads and starts that fall in the middle of a run.

// File: rtl/ring_pkg.sv
package ring_pkg;

   // Non-negative modulo for ring index arithmetic.
   function automatic int ring_mod(input int a, input int n);
      int r;
      r = a % n;
      if (r < 0) r = r + n;
      return r;
   endfunction

endpackage

// File: rtl/ring_seq.sv
module ring_seq #(
   parameter int NODES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   output logic                     busy,
   output logic [$clog2(NODES)-1:0] step,
   output logic                     last,
   output logic                     done
);
   localparam int SW = $clog2(NODES);
   localparam logic [SW-1:0] LAST_STEP = SW'(NODES - 2);

   assign last = busy && (step == LAST_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               step <= '0;
            end
         end else if (step == LAST_STEP) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            step <= step + 1'b1;
         end
      end
   end

   // R5: done lasts a single cycle
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: done only follows the final step
   a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && $past(step) == LAST_STEP));
   // R5: step counter stays in range
   a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (step <= LAST_STEP));
   // R6: a running reduction advances one step per cycle whatever start does
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && step == $past(step) + 1'b1));
endmodule

// File: rtl/ring_node.sv
module ring_node
   import ring_pkg::*;
#(
   parameter int NODES   = 4,
   parameter int WIDTH   = 16,
   parameter int NODE_ID = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(NODES)-1:0] wr_idx,
   input  logic [WIDTH-1:0]         wr_data,
   input  logic                     step_en,
   input  logic [$clog2(NODES)-1:0] step,
   input  logic                     cap_en,
   input  logic [WIDTH-1:0]         rx,
   output logic [WIDTH-1:0]         tx,
   output logic [WIDTH-1:0]         sum_out
);
   localparam int IW = $clog2(NODES);

   logic [NODES-1:0][WIDTH-1:0] mem;
   logic [IW-1:0]               tx_idx;
   logic [IW-1:0]               rx_idx;
   logic [WIDTH-1:0]            acc;
   logic                        wr_ok;

   always_comb begin
      tx_idx = IW'(ring_mod(NODE_ID - int'(step), NODES));
      rx_idx = IW'(ring_mod(NODE_ID - 1 - int'(step), NODES));
   end

   assign tx    = mem[tx_idx];
   assign acc   = mem[rx_idx] + rx;
   assign wr_ok = wr_en && (int'(wr_idx) < NODES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem     <= '0;
         sum_out <= '0;
      end else begin
         if (step_en) begin
            mem[rx_idx] <= acc;
         end else if (wr_ok) begin
            mem[wr_idx] <= wr_data;
         end
         if (cap_en) begin
            sum_out <= acc;
         end
      end
   end

   // R1: an idle write lands in the addressed entry
   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !step_en) |=> (mem[$past(wr_idx)] == $past(wr_data)));
   // R3: a step adds the neighbour's value into the receiving entry
   a_r3_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> (mem[$past(rx_idx)] == $past(mem[rx_idx]) + $past(rx)));
   // R7: storage holds without a write or a step
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !step_en) |=> $stable(mem));
endmodule

// File: rtl/ring_psum_reduce.sv
module ring_psum_reduce #(
   parameter int NODES = 4,
   parameter int WIDTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     load_en,
   input  logic [$clog2(NODES)-1:0] load_node,
   input  logic [$clog2(NODES)-1:0] load_idx,
   input  logic [WIDTH-1:0]         load_data,
   output logic                     done,
   output logic [NODES*WIDTH-1:0]   result
);
   localparam int IW = $clog2(NODES);

   generate
      if (NODES < 2) begin : g_bad_nodes
         $error("ring_psum_reduce: NODES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ring_psum_reduce: WIDTH must be at least 1");
      end
   endgenerate

   logic          busy;
   logic          last;
   logic [IW-1:0] step;
   logic [WIDTH-1:0] tx_bus [NODES];

   ring_seq #(.NODES(NODES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .step  (step),
      .last  (last),
      .done  (done)
   );

   generate
      for (genvar j = 0; j < NODES; j++) begin : g_node
         localparam int PREV = (j + NODES - 1) % NODES;
         logic wr_sel;
         assign wr_sel = load_en && !busy && (int'(load_node) == j);

         ring_node #(.NODES(NODES), .WIDTH(WIDTH), .NODE_ID(j)) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel),
            .wr_idx  (load_idx),
            .wr_data (load_data),
            .step_en (busy),
            .step    (step),
            .cap_en  (last),
            .rx      (tx_bus[PREV]),
            .tx      (tx_bus[j]),
            .sum_out (result[j*WIDTH +: WIDTH])
         );
      end
   endgenerate

   // R8: results move only together with the completion pulse
   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
endmodule

// File: tb/test_ring_psum_reduce.sv
`timescale 1ns/1ps
module test_ring_psum_reduce;
   localparam int N = 4;
   localparam int W = 16;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic load_en = 1'b0;
   logic [IW-1:0] load_node = '0;
   logic [IW-1:0] load_idx = '0;
   logic [W-1:0]  load_data = '0;
   logic done;
   logic [N*W-1:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ring_psum_reduce #(.NODES(N), .WIDTH(W)) i_ring_psum_reduce (
      .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
      .load_node(load_node), .load_idx(load_idx), .load_data(load_data),
      .done(done), .result(result)
   );

   localparam logic [W-1:0] SEEDS [4] = '{16'h0001, 16'h0100, 16'h7FF0, 16'hFFFF};

   function automatic logic [W-1:0] pat(input logic [W-1:0] seed, input int n, input int k);
      return W'(seed * (n + 1)) + W'(k * 16'h0111) + W'(n * 16'h0023);
   endfunction

   function automatic logic [W-1:0] total(input logic [W-1:0] seed, input int k);
      logic [W-1:0] s = '0;
      for (int n = 0; n < N; n++) s = s + pat(seed, n, k);
      return s;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_all(input logic [W-1:0] seed);
      for (int n = 0; n < N; n++) begin
         for (int k = 0; k < N; k++) begin
            load_en = 1'b1; load_node = IW'(n); load_idx = IW'(k);
            load_data = pat(seed, n, k);
            @(negedge clk);
         end
      end
      load_en = 1'b0;
   endtask

   task automatic check_results(input logic [W-1:0] seed, input string req);
      for (int j = 0; j < N; j++)
         check(req, 32'(result[j*W +: W]), 32'(total(seed, (j + 1) % N)));
   endtask

   // start pulse, returns edges counted until done is seen
   task automatic run(output int lat);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int lat;
      int extra;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check("R9 done", 32'(done), 32'd0);
      check("R9 result", 32'(result == '0), 32'd1);

      // Vector table: R1 load, R2 routing, R3 wrap add, R4 totals, R5 timing
      for (int v = 0; v < 4; v++) begin
         load_all(SEEDS[v]);
         run(lat);
         check("R5 latency", 32'(lat), 32'(N - 1));
         check_results(SEEDS[v], "R4/R2/R3 totals");
         @(negedge clk);
         check("R5 done one cycle", 32'(done), 32'd0);
      end

      // R8: loads after completion leave results unchanged
      load_all(16'h1234);
      repeat (3) @(negedge clk);
      check("R8 done low", 32'(done), 32'd0);
      check_results(SEEDS[3], "R8 result hold");

      // R6 and R7: mid-run start and load are ignored
      load_all(16'h0A05);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      load_en = 1'b1; load_node = '0; load_idx = IW'(1); load_data = 16'h7777;
      @(negedge clk);
      load_en = 1'b0;
      start = 1'b1;
      check("R6 no early done", 32'(done), 32'd0);
      @(negedge clk);
      start = 1'b0;
      check("R6 no early done", 32'(done), 32'd0);
      @(negedge clk);
      check("R6 done timing", 32'(done), 32'd1);
      check_results(16'h0A05, "R7 mid-run load ignored");
      extra = 0;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         if (done) extra++;
      end
      check("R6 no second done", 32'(extra), 32'd0);

      // R1: single-entry difference shows up in the matching total
      load_all(16'h0000);
      load_en = 1'b1; load_node = IW'(2); load_idx = IW'(3); load_data = 16'h5000;
      @(negedge clk);
      load_en = 1'b0;
      run(lat);
      check("R1 single write", 32'(result[2*W +: W]),
            32'(W'(total(16'h0000, 3) - pat(16'h0000, 2, 3) + 16'h5000)));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule